// File: doc/BRIEF.md
# Presence-Detect Parameter Decoder

This block sits behind whatever serial transport reads a memory module's presence-detect storage. It receives the first 64 bytes of that storage as a stream: one byte per cycle when a valid strobe is high, each tagged with its index. It checks that the bytes arrive in order and that the final byte holds the correct checksum. It also pulls out the fields a memory controller needs to configure itself.

Geometry and feature fields pass through unchanged: row and column address widths, rank and internal bank counts, and the CAS latency and burst length support maps. The four minimum-delay fields are in whole nanoseconds. The block turns each one into a clock count for a clock period that is fixed by a parameter, rounding up. The decoded set is published together when the last byte arrives, along with a one-cycle completion pulse and two status flags.

Top module: `spd_cfg_decoder`

## Requirements
- R1: After reset, every output is zero, including done, cksum_ok and order_err.
- R2: A valid byte with index 63 ends the frame. In the next cycle done is high for exactly one cycle, and all decoded outputs take their new values in that same cycle.
- R3: cksum_ok is published as 1 only when the frame arrived in order and byte 63 equals the low 8 bits of the sum of bytes 0 to 62. Otherwise it is published as 0.
- R4: trp_clk, trrd_clk, trcd_clk and tras_clk come from bytes 27, 28, 29 and 30 respectively, each a count of whole nanoseconds. Each output is the smallest clock count whose total time (count × CLK_PS picoseconds) is at least that value, and never less than 1.
- R5: A clock count that does not fit in CNT_W bits saturates at 2^CNT_W-1.
- R6: row_bits is byte 3, col_bits is byte 4, rank_cnt is byte 5 and dev_bank_cnt is byte 17.
- R7: cas_set is bits 6..0 of byte 18, where bit n-1 means CAS latency n is supported. burst_set is {byte16[7], byte16[3:0]}: bit 4 means full page, and bits 3..0 mean lengths 8, 4, 2 and 1.
- R8: tck_min_x10 is the minimum cycle time from byte 9 in tenths of a nanosecond: the upper nibble × 10 plus the lower nibble. hdr_ok is 1 when byte 0 is 0x80 and byte 2 is 0x04.
- R9: A valid byte whose index is neither the expected next index nor 0 marks the frame as out of order. When that frame ends, order_err is published as 1 and cksum_ok as 0, and the byte is not used.
- R10: A valid byte with index 0 always starts a new frame. Any partial frame, and any out-of-order mark it carries, is discarded.
- R11: Between done pulses, all decoded outputs and flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_vld | input | 1 | Byte strobe |
| byte_idx | input | IDX_W | Index of the byte |
| byte_dat | input | 8 | Byte value |
| row_bits | output | 8 | Row address bits |
| col_bits | output | 8 | Column address bits |
| rank_cnt | output | 8 | Module rank count |
| dev_bank_cnt | output | 8 | Internal device bank count |
| tck_min_x10 | output | 8 | Minimum cycle time, tenths of ns |
| cas_set | output | 7 | Supported CAS latency map |
| burst_set | output | 5 | Supported burst length map |
| hdr_ok | output | 1 | Header size and type match |
| trp_clk | output | CNT_W | Precharge delay in clocks |
| trrd_clk | output | CNT_W | Activate-to-activate delay in clocks |
| trcd_clk | output | CNT_W | Row-to-column delay in clocks |
| tras_clk | output | CNT_W | Row active time in clocks |
| cksum_ok | output | 1 | Checksum matched on an in-order frame |
| order_err | output | 1 | Frame had an out-of-order byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with CLK_PS = 7500 and CNT_W = 4. A 7.5 ns period leaves a remainder for most nanosecond values, so the round-up is actually exercised: 16 ns and 20 ns both become 3 clocks, while 30 ns divides evenly into 4. The narrow count width makes 255 ns (34 clocks) overflow, which exercises saturation at 15. A zero field exercises the floor of 1.

// File: rtl/spd_dec_pkg.sv
package spd_dec_pkg;

    // Byte offsets the decoder reads; positions are fixed by the storage layout.
    localparam int OFS_NBYTES = 0;
    localparam int OFS_MTYPE  = 2;
    localparam int OFS_ROWS   = 3;
    localparam int OFS_COLS   = 4;
    localparam int OFS_RANKS  = 5;
    localparam int OFS_TCK    = 9;
    localparam int OFS_BURST  = 16;
    localparam int OFS_BANKS  = 17;
    localparam int OFS_CAS    = 18;
    localparam int OFS_TRP    = 27;
    localparam int OFS_TRRD   = 28;
    localparam int OFS_TRCD   = 29;
    localparam int OFS_TRAS   = 30;

    typedef struct packed {
        logic [7:0] nbytes;
        logic [7:0] mtype;
        logic [7:0] rows;
        logic [7:0] cols;
        logic [7:0] ranks;
        logic [7:0] tck;
        logic [7:0] burst;
        logic [7:0] banks;
        logic [7:0] cas;
        logic [7:0] trp;
        logic [7:0] trrd;
        logic [7:0] trcd;
        logic [7:0] tras;
    } spd_stage_t;

    // Round-up division of a nanosecond figure by a picosecond period.
    function automatic int unsigned ns_to_clk(input int unsigned ns,
                                              input int unsigned per_ps,
                                              input int unsigned maxv);
        int unsigned q;
        q = (ns * 1000 + per_ps - 1) / per_ps;
        if (q < 1)    q = 1;
        if (q > maxv) q = maxv;
        return q;
    endfunction

endpackage

// File: rtl/spd_seq_track.sv
module spd_seq_track #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       dat,
    output logic             accept,
    output logic             end_evt,
    output logic             frame_ok,
    output logic             sum_ok
);
    localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

    typedef struct packed {
        logic [IDX_W-1:0] nxt;
        logic             bad;
        logic [7:0]       sum;
    } trk_t;

    trk_t s_d, s_q;
    logic is_start, hit;

    always_comb begin
        is_start = vld && (idx == '0);
        hit      = vld && (idx == s_q.nxt);
        accept   = is_start || hit;
        end_evt  = vld && (idx == LAST);
        frame_ok = end_evt && hit && !s_q.bad;
        sum_ok   = frame_ok && (s_q.sum == dat);

        s_d = s_q;
        if (end_evt) begin
            s_d.nxt = '0;
            s_d.bad = 1'b0;
            s_d.sum = '0;
        end else if (is_start) begin
            s_d.nxt = IDX_W'(1);
            s_d.bad = 1'b0;
            s_d.sum = dat;
        end else if (hit) begin
            s_d.nxt = s_q.nxt + IDX_W'(1);
            s_d.sum = s_q.sum + dat;
        end else if (vld) begin
            s_d.bad = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/spd_field_stage.sv
module spd_field_stage import spd_dec_pkg::*; #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       dat,
    output spd_stage_t       stage
);
    spd_stage_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (accept) begin
            case (int'(idx))
                OFS_NBYTES: s_d.nbytes = dat;
                OFS_MTYPE:  s_d.mtype  = dat;
                OFS_ROWS:   s_d.rows   = dat;
                OFS_COLS:   s_d.cols   = dat;
                OFS_RANKS:  s_d.ranks  = dat;
                OFS_TCK:    s_d.tck    = dat;
                OFS_BURST:  s_d.burst  = dat;
                OFS_BANKS:  s_d.banks  = dat;
                OFS_CAS:    s_d.cas    = dat;
                OFS_TRP:    s_d.trp    = dat;
                OFS_TRRD:   s_d.trrd   = dat;
                OFS_TRCD:   s_d.trcd   = dat;
                OFS_TRAS:   s_d.tras   = dat;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stage = s_q;
endmodule

// File: rtl/spd_ns_to_clk.sv
module spd_ns_to_clk import spd_dec_pkg::*; #(
    parameter int unsigned CLK_PS = 10000,
    parameter int          CNT_W  = 6
) (
    input  logic [7:0]       ns,
    output logic [CNT_W-1:0] clks
);
    localparam int unsigned MAXV = (1 << CNT_W) - 1;

    always_comb clks = CNT_W'(ns_to_clk({24'b0, ns}, CLK_PS, MAXV));
endmodule

// File: rtl/spd_cfg_decoder.sv
module spd_cfg_decoder import spd_dec_pkg::*; #(
    parameter int unsigned CLK_PS = 10000,
    parameter int          CNT_W  = 6,
    parameter int          IDX_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       byte_dat,
    output logic [7:0]       row_bits,
    output logic [7:0]       col_bits,
    output logic [7:0]       rank_cnt,
    output logic [7:0]       dev_bank_cnt,
    output logic [7:0]       tck_min_x10,
    output logic [6:0]       cas_set,
    output logic [4:0]       burst_set,
    output logic             hdr_ok,
    output logic [CNT_W-1:0] trp_clk,
    output logic [CNT_W-1:0] trrd_clk,
    output logic [CNT_W-1:0] trcd_clk,
    output logic [CNT_W-1:0] tras_clk,
    output logic             cksum_ok,
    output logic             order_err,
    output logic             done
);
    localparam int N_TIM = 4;

    typedef struct packed {
        logic [7:0]       rows;
        logic [7:0]       cols;
        logic [7:0]       ranks;
        logic [7:0]       banks;
        logic [7:0]       tck10;
        logic [6:0]       cas;
        logic [4:0]       burst;
        logic             hdr;
        logic [CNT_W-1:0] t_rp;
        logic [CNT_W-1:0] t_rrd;
        logic [CNT_W-1:0] t_rcd;
        logic [CNT_W-1:0] t_ras;
        logic             ck_ok;
        logic             ord_err;
        logic             pulse;
    } pub_t;

    logic       accept, end_evt, frame_ok, sum_ok;
    spd_stage_t stg;
    logic [7:0]       ns_in  [N_TIM];
    logic [CNT_W-1:0] clk_out[N_TIM];
    pub_t p_d, p_q;

    spd_seq_track #(.IDX_W(IDX_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .vld(byte_vld), .idx(byte_idx), .dat(byte_dat),
        .accept(accept), .end_evt(end_evt), .frame_ok(frame_ok), .sum_ok(sum_ok)
    );

    spd_field_stage #(.IDX_W(IDX_W)) u_stg (
        .clk(clk), .rst_n(rst_n), .accept(accept), .idx(byte_idx), .dat(byte_dat),
        .stage(stg)
    );

    assign ns_in[0] = stg.trp;
    assign ns_in[1] = stg.trrd;
    assign ns_in[2] = stg.trcd;
    assign ns_in[3] = stg.tras;

    for (genvar g = 0; g < N_TIM; g++) begin : g_tim
        spd_ns_to_clk #(.CLK_PS(CLK_PS), .CNT_W(CNT_W)) u_cvt (
            .ns(ns_in[g]), .clks(clk_out[g])
        );
    end

    always_comb begin
        p_d       = p_q;
        p_d.pulse = end_evt;
        if (end_evt) begin
            p_d.rows    = stg.rows;
            p_d.cols    = stg.cols;
            p_d.ranks   = stg.ranks;
            p_d.banks   = stg.banks;
            p_d.tck10   = {4'b0, stg.tck[7:4]} * 8'd10 + {4'b0, stg.tck[3:0]};
            p_d.cas     = stg.cas[6:0];
            p_d.burst   = {stg.burst[7], stg.burst[3:0]};
            p_d.hdr     = (stg.nbytes == 8'h80) && (stg.mtype == 8'h04);
            p_d.t_rp    = clk_out[0];
            p_d.t_rrd   = clk_out[1];
            p_d.t_rcd   = clk_out[2];
            p_d.t_ras   = clk_out[3];
            p_d.ck_ok   = sum_ok;
            p_d.ord_err = !frame_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign row_bits     = p_q.rows;
    assign col_bits     = p_q.cols;
    assign rank_cnt     = p_q.ranks;
    assign dev_bank_cnt = p_q.banks;
    assign tck_min_x10  = p_q.tck10;
    assign cas_set      = p_q.cas;
    assign burst_set    = p_q.burst;
    assign hdr_ok       = p_q.hdr;
    assign trp_clk      = p_q.t_rp;
    assign trrd_clk     = p_q.t_rrd;
    assign trcd_clk     = p_q.t_rcd;
    assign tras_clk     = p_q.t_ras;
    assign cksum_ok     = p_q.ck_ok;
    assign order_err    = p_q.ord_err;
    assign done         = p_q.pulse;
endmodule

// File: rtl/spd_cfg_checker.sv
module spd_cfg_checker #(
    parameter int CNT_W = 6,
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_vld,
    input logic [IDX_W-1:0] byte_idx,
    input logic             done,
    input logic             cksum_ok,
    input logic             order_err,
    input logic [CNT_W-1:0] trp_clk,
    input logic [CNT_W-1:0] tras_clk,
    input logic [7:0]       row_bits,
    input logic [6:0]       cas_set
);
    localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

    a_r2_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(byte_vld && (byte_idx == LAST)));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cksum_ok && order_err));

    a_r4_min_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (trp_clk != '0) && (tras_clk != '0));

    a_r11_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(row_bits) && $stable(cas_set) && $stable(cksum_ok) && $stable(order_err));
endmodule

bind spd_cfg_decoder spd_cfg_checker #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_idx(byte_idx),
    .done(done), .cksum_ok(cksum_ok), .order_err(order_err),
    .trp_clk(trp_clk), .tras_clk(tras_clk), .row_bits(row_bits), .cas_set(cas_set)
);

// File: tb/sim_spd_cfg_decoder.sv
module sim_spd_cfg_decoder;
    localparam int unsigned PER = 7500;
    localparam int CW = 4;
    localparam int CAP = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vld = 1'b0;
    logic [5:0] idx = '0;
    logic [7:0] dat = '0;
    logic [7:0] row_bits, col_bits, rank_cnt, dev_bank_cnt, tck_min_x10;
    logic [6:0] cas_set;
    logic [4:0] burst_set;
    logic hdr_ok, cksum_ok, order_err, done;
    logic [CW-1:0] trp_clk, trrd_clk, trcd_clk, tras_clk;

    always #2 clk = ~clk;

    spd_cfg_decoder #(.CLK_PS(PER), .CNT_W(CW), .IDX_W(6)) u0 (
        .clk(clk), .rst_n(rst_n), .byte_vld(vld), .byte_idx(idx), .byte_dat(dat),
        .row_bits(row_bits), .col_bits(col_bits), .rank_cnt(rank_cnt),
        .dev_bank_cnt(dev_bank_cnt), .tck_min_x10(tck_min_x10), .cas_set(cas_set),
        .burst_set(burst_set), .hdr_ok(hdr_ok), .trp_clk(trp_clk), .trrd_clk(trrd_clk),
        .trcd_clk(trcd_clk), .tras_clk(tras_clk), .cksum_ok(cksum_ok),
        .order_err(order_err), .done(done)
    );

    int compared = 0, mismatched = 0;
    bit cmp_en = 0, finished = 0;

    // ---- reference model ----
    int m_next = 0, m_bad = 0, m_sum = 0;
    int m_mem [64];
    int e_rows, e_cols, e_ranks, e_banks, e_tck, e_cas, e_burst, e_hdr;
    int e_trp, e_trrd, e_trcd, e_tras, e_ck, e_ord, e_done;

    function automatic int clocks_for(int ns);
        int c = 1;
        while (c * int'(PER) < ns * 1000) c++;
        if (c > CAP) c = CAP;
        return c;
    endfunction

    task automatic model_reset();
        m_next = 0; m_bad = 0; m_sum = 0;
        foreach (m_mem[i]) m_mem[i] = 0;
        e_rows = 0; e_cols = 0; e_ranks = 0; e_banks = 0; e_tck = 0; e_cas = 0;
        e_burst = 0; e_hdr = 0; e_trp = 0; e_trrd = 0; e_trcd = 0; e_tras = 0;
        e_ck = 0; e_ord = 0; e_done = 0;
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            e_done = 0;
            if (vld) begin
                if (idx == 6'd63) begin
                    int in_order;
                    in_order = (m_next == 63) && (m_bad == 0);
                    e_done  = 1;
                    e_ck    = (in_order && ((m_sum % 256) == int'(dat))) ? 1 : 0;
                    e_ord   = in_order ? 0 : 1;
                    e_rows  = m_mem[3];  e_cols = m_mem[4];
                    e_ranks = m_mem[5];  e_banks = m_mem[17];
                    e_tck   = (m_mem[9] / 16) * 10 + (m_mem[9] % 16);
                    e_cas   = m_mem[18] % 128;
                    e_burst = ((m_mem[16] / 128) * 16) + (m_mem[16] % 16);
                    e_hdr   = (m_mem[0] == 128 && m_mem[2] == 4) ? 1 : 0;
                    e_trp   = clocks_for(m_mem[27]);
                    e_trrd  = clocks_for(m_mem[28]);
                    e_trcd  = clocks_for(m_mem[29]);
                    e_tras  = clocks_for(m_mem[30]);
                    m_next = 0; m_bad = 0; m_sum = 0;
                end else if (idx == 6'd0) begin
                    m_mem[0] = int'(dat); m_sum = int'(dat); m_next = 1; m_bad = 0;
                end else if (int'(idx) == m_next) begin
                    m_mem[idx] = int'(dat); m_sum += int'(dat); m_next++;
                end else begin
                    m_bad = 1;
                end
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            compared++;
            chk("R2 done", int'(done), e_done);
            chk("R3 cksum_ok", int'(cksum_ok), e_ck);
            chk("R9 order_err", int'(order_err), e_ord);
            chk("R6 row_bits", int'(row_bits), e_rows);
            chk("R6 col_bits", int'(col_bits), e_cols);
            chk("R6 rank_cnt", int'(rank_cnt), e_ranks);
            chk("R6 dev_bank_cnt", int'(dev_bank_cnt), e_banks);
            chk("R7 cas_set", int'(cas_set), e_cas);
            chk("R7 burst_set", int'(burst_set), e_burst);
            chk("R8 tck_min_x10", int'(tck_min_x10), e_tck);
            chk("R8 hdr_ok", int'(hdr_ok), e_hdr);
            chk("R4 R5 trp_clk", int'(trp_clk), e_trp);
            chk("R4 R5 trrd_clk", int'(trrd_clk), e_trrd);
            chk("R4 R5 trcd_clk", int'(trcd_clk), e_trcd);
            chk("R4 R5 tras_clk", int'(tras_clk), e_tras);
        end
    end

    // ---- stimulus ----
    int img [64];

    task automatic build(int seed, int rows, int cols, int tck, int cas, int burst,
                         int trp, int trrd, int trcd, int tras, int mtype);
        int s = 0;
        for (int i = 0; i < 63; i++) img[i] = (seed * 7 + i * 13) % 256;
        img[0] = 8'h80; img[2] = mtype; img[3] = rows; img[4] = cols;
        img[5] = 1 + seed % 2; img[9] = tck; img[16] = burst; img[17] = 4;
        img[18] = cas; img[27] = trp; img[28] = trrd; img[29] = trcd; img[30] = tras;
        for (int i = 0; i < 63; i++) s += img[i];
        img[63] = s % 256;
    endtask

    task automatic put(int i, int d);
        @(negedge clk); vld = 1'b1; idx = 6'(i); dat = 8'(d);
    endtask

    task automatic gap(int n);
        for (int k = 0; k < n; k++) begin @(negedge clk); vld = 1'b0; end
    endtask

    task automatic send(int from, int upto, int skip, int gap_every);
        for (int i = from; i <= upto; i++) begin
            if (i != skip) put(i, img[i]);
            if (gap_every > 0 && (i % gap_every) == 0) gap(1);
        end
        gap(2);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        compared++;   // R1: reset state at the ports
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset cksum_ok", int'(cksum_ok), 0);
        chk("R1 reset order_err", int'(order_err), 0);
        chk("R1 reset row_bits", int'(row_bits), 0);
        chk("R1 reset trp_clk", int'(trp_clk), 0);
        rst_n = 1'b1;
        cmp_en = 1;

        // typical frame, gaps, rounding 16/20 ns -> 3, 45 ns -> 6
        build(1, 8'h0C, 8'h09, 8'hA0, 8'h06, 8'h8F, 8'h14, 8'h10, 8'h14, 8'h2D, 8'h04);
        send(0, 63, -1, 7);
        gap(5);
        compared++;   // R11: outputs hold while idle
        chk("R11 hold row_bits", int'(row_bits), 8'h0C);
        chk("R11 hold cksum_ok", int'(cksum_ok), 1);

        // zero, exact and saturating timings with a wrong checksum
        build(2, 8'h0D, 8'h0B, 8'hC5, 8'h04, 8'h0C, 8'h00, 8'h0F, 8'h1E, 8'hFF, 8'h04);
        img[63] = (img[63] + 1) % 256;
        send(0, 63, -1, 0);

        // out-of-order frame: index 10 never arrives, bad type code
        build(3, 8'h0C, 8'h0A, 8'hA0, 8'h02, 8'h01, 8'h14, 8'h14, 8'h14, 8'h3C, 8'h08);
        send(0, 63, 10, 0);

        // partial out-of-order frame abandoned by a restart at index 0
        build(4, 8'h0C, 8'h09, 8'h80, 8'h06, 8'h8F, 8'h14, 8'h10, 8'h14, 8'h2D, 8'h04);
        send(0, 20, 5, 0);
        build(5, 8'h0D, 8'h0B, 8'hC0, 8'h06, 8'h8F, 8'h1E, 8'h14, 8'h14, 8'h3C, 8'h04);
        send(0, 63, -1, 0);
        compared++;   // R10: restarted frame decoded cleanly
        chk("R10 restart row_bits", int'(row_bits), 8'h0D);
        chk("R10 restart order_err", int'(order_err), 0);
        chk("R10 restart cksum_ok", int'(cksum_ok), 1);

        // stray last byte with no frame in progress
        put(63, 8'h55);
        gap(3);
        compared++;   // R9: lone last byte flagged
        chk("R9 stray order_err", int'(order_err), 1);

        gap(4);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule